// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy Super I/O device. A host reaches it over a simple byte-wide I/O bus. That bus has an address, a write strobe, a read strobe and 8-bit write and read data. Two adjacent I/O addresses act as an index/data pair. The host writes a register number to the index port, then reads or writes that register through the data port.

The configuration space is locked after reset. The host opens it by writing a fixed four-byte key to the index port. It closes it again by writing the value 0x02 to configuration register 0x02. The open space contains:

- a logical-device select register;
- a read-only 16-bit chip identifier and a 4-bit revision, both set by parameters;
- a 16-bit GPIO base address, which is visible only while the GPIO logical device is selected.

The base address, the device select and the lock state are driven straight out to a neighbouring GPIO bank.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked. The device select reads 0x00 and the GPIO base holds the parameter `BASE_RESET`.
- R2: The block opens in the clock cycle after the fourth byte of the index-port write sequence 0x87, 0x01, 0x55, 0x55.
- R3: While locked, an index-port byte that does not match the next expected key byte restarts matching. A mismatching 0x87 counts as a fresh first key byte.
- R4: While locked, data-port reads return 0xFF and data-port writes change no register.
- R5: While open, a register is reached by writing its number to the index port (`IDX_ADDR`, default 0x2E) and then accessing the data port (`DAT_ADDR`, default 0x2F). Register 0x07 is the read/write logical-device select.
- R6: Register 0x20 reads the high byte of `CHIP_ID` and 0x21 reads the low byte. Register 0x22 reads `CHIP_REV` in bits 3:0 and zero in bits 7:4. Writes to these registers have no effect.
- R7: With the device select equal to `GPIO_LDN` (default 0x07), register 0x62 is the high byte and 0x63 the low byte of the GPIO base, both read/write. With any other device selected, these registers read 0xFF and ignore writes.
- R8: Writing 0x02 to register 0x02 locks the block again from the next cycle on. Any other value written there leaves it open.
- R9: Unimplemented registers read 0xFF. The read data is 0xFF whenever no data-port read is in progress. Accesses to any other I/O address change nothing.
- R10: Register writes take effect at the clock edge of the write strobe. Reads return the current register value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| cfg_open | output | 1 | Configuration space unlocked |
| ldn_sel | output | 8 | Selected logical device |
| gpio_sel | output | 1 | GPIO logical device selected |
| gpio_base | output | 16 | GPIO bank base address |

## Verification
The bench builds the block with a chip identifier of 0x8761 and revision 0x5. These values differ from the defaults and are asymmetric, so a swap of the identifier's high and low bytes or a loss of the revision nibble shows up in the read data. A base-address reset of 0x0290 gives distinct non-zero high and low bytes, which exposes byte-lane mistakes at registers 0x62 and 0x63. The port addresses keep their defaults, which leaves neighbouring addresses free to probe the address decode.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter logic [15:0] IDX_ADDR   = 16'h002E,
  parameter logic [15:0] DAT_ADDR   = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'h8728,
  parameter logic [3:0]  CHIP_REV   = 4'h1,
  parameter logic [7:0]  GPIO_LDN   = 8'h07,
  parameter logic [15:0] BASE_RESET = 16'h0A00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        cfg_open,
  output logic [7:0]  ldn_sel,
  output logic        gpio_sel,
  output logic [15:0] gpio_base
);
  localparam logic [31:0] KEY = 32'h8701_5555;

  logic [1:0] key_pos;
  logic [7:0] idx;
  logic [7:0] key_byte;
  logic       wr_idx, wr_dat, rd_dat;

  assign wr_idx   = io_wr && io_addr == IDX_ADDR;
  assign wr_dat   = io_wr && io_addr == DAT_ADDR;
  assign rd_dat   = io_rd && io_addr == DAT_ADDR;
  assign key_byte = KEY[31 - 8*key_pos -: 8];
  assign gpio_sel = ldn_sel == GPIO_LDN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_open  <= 1'b0;
      key_pos   <= 2'd0;
      idx       <= 8'h00;
      ldn_sel   <= 8'h00;
      gpio_base <= BASE_RESET;
    end else if (!cfg_open) begin
      if (wr_idx) begin
        if (io_wdata == key_byte) begin
          key_pos <= key_pos + 2'd1;
          if (key_pos == 2'd3) cfg_open <= 1'b1;
        end else begin
          key_pos <= (io_wdata == KEY[31:24]) ? 2'd1 : 2'd0;
        end
      end
    end else if (wr_idx) begin
      idx <= io_wdata;
    end else if (wr_dat) begin
      case (idx)
        8'h02: if (io_wdata == 8'h02) begin
                 cfg_open <= 1'b0;
                 key_pos  <= 2'd0;
               end
        8'h07: ldn_sel <= io_wdata;
        8'h62: if (gpio_sel) gpio_base[15:8] <= io_wdata;
        8'h63: if (gpio_sel) gpio_base[7:0]  <= io_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (rd_dat && cfg_open) begin
      case (idx)
        8'h07: io_rdata = ldn_sel;
        8'h20: io_rdata = CHIP_ID[15:8];
        8'h21: io_rdata = CHIP_ID[7:0];
        8'h22: io_rdata = {4'h0, CHIP_REV};
        8'h62: if (gpio_sel) io_rdata = gpio_base[15:8];
        8'h63: if (gpio_sel) io_rdata = gpio_base[7:0];
        default: io_rdata = 8'hFF;
      endcase
    end
  end

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_ADDR && io_wdata == 8'h55));
  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_wr && io_addr == DAT_ADDR) |=> ($stable(ldn_sel) && $stable(gpio_base)));
  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> io_rdata == 8'hFF);
  a_r7_base_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_sel |=> $stable(gpio_base));
  a_r8_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && io_addr == DAT_ADDR && idx == 8'h02 && io_wdata == 8'h02) |=> !cfg_open);
  a_r9_idle_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'hFF);
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam logic [15:0] IDX = 16'h002E, DAT = 16'h002F;
  localparam logic [15:0] ID = 16'h8761, BRST = 16'h0290;
  localparam logic [3:0]  REV = 4'h5;

  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0, io_rdata, ldn_sel;
  logic        cfg_open, gpio_sel;
  logic [15:0] gpio_base;
  int checks = 0, errors = 0;

  logic m_open; logic [1:0] m_kp; logic [7:0] m_idx, m_ldn; logic [15:0] m_base;

  always #5 clk = ~clk;

  sio_cfg_port #(.CHIP_ID(ID), .CHIP_REV(REV), .BASE_RESET(BRST)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .ldn_sel(ldn_sel), .gpio_sel(gpio_sel), .gpio_base(gpio_base));

  function automatic logic [7:0] key_at(input logic [1:0] k);
    case (k) 2'd0: return 8'h87; 2'd1: return 8'h01; default: return 8'h55; endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (a != DAT || !m_open) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return ID[15:8];
      8'h21: return ID[7:0];
      8'h22: return {4'h0, REV};
      8'h62: return (m_ldn == 8'h07) ? m_base[15:8] : 8'hFF;
      8'h63: return (m_ldn == 8'h07) ? m_base[7:0] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (!m_open) begin
      if (a == IDX) begin
        if (d == key_at(m_kp)) begin
          if (m_kp == 2'd3) m_open = 1;
          m_kp = m_kp + 1;
        end else m_kp = (d == 8'h87) ? 2'd1 : 2'd0;
      end
    end else if (a == IDX) m_idx = d;
    else if (a == DAT) begin
      if (m_idx == 8'h02 && d == 8'h02) begin m_open = 0; m_kp = 0; end
      else if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h62 && m_ldn == 8'h07) m_base[15:8] = d;
      else if (m_idx == 8'h63 && m_ldn == 8'h07) m_base[7:0] = d;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, cfg_open, m_open);
    check(req, ldn_sel, m_ldn);
    check(req, gpio_base, m_base);
    check(req, gpio_sel, m_ldn == 8'h07);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    @(negedge clk); io_addr = a; io_rd = 1; #1;
    check(req, io_rdata, exp_read(a));
    @(negedge clk); io_rd = 0;
  endtask

  task automatic unlock();
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_open = 0; m_kp = 0; m_idx = 0; m_ldn = 0; m_base = BRST;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");
    check("R1 reset value", gpio_base, 16'h0290);
    rd(DAT, "R1 locked read");

    wr(DAT, 8'h07); check_state("R4 locked write");
    rd(DAT, "R4 locked read");
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h87); wr(IDX, 8'h01);
    wr(IDX, 8'h55); check("R3 restart not yet open", cfg_open, 1'b0);
    wr(IDX, 8'h55); check("R3 restart via 0x87", cfg_open, 1'b1);
    wr(IDX, 8'h02); wr(DAT, 8'h02); check("R8 exit", cfg_open, 1'b0);
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h54);
    wr(IDX, 8'h55); check("R3 wrong byte", cfg_open, 1'b0);
    unlock(); check("R2 key opens", cfg_open, 1'b1);
    wr(IDX, 8'h20); rd(DAT, "R6 id high");
    check("R6 id high value", exp_read(DAT), 8'h87);
    wr(IDX, 8'h21); rd(DAT, "R6 id low");
    wr(DAT, 8'h00); rd(DAT, "R6 id write ignored");
    wr(IDX, 8'h22); rd(DAT, "R6 revision");
    wr(IDX, 8'h62); wr(DAT, 8'hAB); check_state("R7 base blocked");
    rd(DAT, "R7 base hidden");
    wr(IDX, 8'h07); wr(DAT, 8'h07); check_state("R5 select ldn");
    rd(DAT, "R5 ldn readback");
    wr(IDX, 8'h62); wr(DAT, 8'h12); wr(IDX, 8'h63); wr(DAT, 8'h34);
    check("R7 base written", gpio_base, 16'h1234);
    rd(DAT, "R7 base low read");
    wr(IDX, 8'h02); wr(DAT, 8'h03); check("R8 other value stays open", cfg_open, 1'b1);
    wr(IDX, 8'h55); rd(DAT, "R9 unimplemented");
    rd(IDX, "R9 index read");
    wr(16'h002D, 8'h07); wr(16'h0030, 8'h00); check_state("R9 other address");
    wr(IDX, 8'h07); wr(DAT, 8'h03); rd(DAT, "R10 same-cycle read");
    check_state("R10 write edge");

    for (int i = 0; i < 400; i++) begin
      int c;
      logic [15:0] a;
      logic [7:0] d;
      c = $urandom_range(0, 12);
      if (c == 0) unlock();
      else begin
        a = ($urandom_range(0, 9) == 0) ? 16'h0030 : (($urandom_range(0, 1) == 0) ? IDX : DAT);
        case ($urandom_range(0, 7))
          0: d = 8'h87; 1: d = 8'h01; 2: d = 8'h55; 3: d = 8'h02;
          4: d = 8'h07; 5: d = 8'h62 + 8'($urandom_range(0, 1));
          6: d = 8'h20 + 8'($urandom_range(0, 2));
          default: d = 8'($urandom);
        endcase
        if ($urandom_range(0, 2) == 0) rd(a, "R5 random read");
        else wr(a, d);
      end
      check_state("R2 R5 R7 R8 random state");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule